// File: doc/BRIEF.md
# Page-table-walk attribute hint control register

This block is a 64-bit system control register that decides the two hardware attribute hint bits placed on every memory request issued by the page-table walker. It holds four enable bits and four value bits, split into a lower-base half and an upper-base half, one enable and one value per hint bit per half. A hint bit on a walk is 1 only when both its enable and its value are set for the half that the walk uses.

Software reaches the register through a system-register access port. The port carries the access encoding, a read/write flag, write data, the current privilege level, the security state, the hypervisor host-mode bit and the trap-general bit. The block grants, faults or redirects each access that it recognises, and reports the result one cycle later. It ignores encodings that belong to other registers. The walker presents a request with a base-select bit and receives the registered 2-bit hint one cycle later.

Top module: `walk_hint_ctrl`

## Requirements
- R1: After reset every stored field is 0, a read at level 3 returns 0, walks get hint 0, and `acc_ack_o`, `acc_fault_o`, `acc_redirect_o` and `hint_valid_o` are low.
- R2: A granted write keeps only bits 0, 1, 4, 5, 8, 9, 12 and 13 of the write data and discards all other bits. Reads return zero in every other bit position.
- R3: For a lower-base walk, hint bit k equals stored bit k AND stored bit 8+k. For an upper-base walk, hint bit k equals stored bit 4+k AND stored bit 12+k (k = 0, 1).
- R4: `hint_valid_o` is high exactly one cycle after `walk_valid_i`, with `walk_upper_i` = 1 selecting the upper base. `hint_o` is 0 whenever `hint_valid_o` is low.
- R5: The primary encoding is op0=3, op1=0, CRn=15, CRm=7, op2=0. An encoding that is neither this one nor an active alias gets no response, and the stored value does not change.
- R6: A primary-encoding access at privilege level 0 always faults.
- R7: In the secure state (`secure_i`=1), primary-encoding accesses are granted at levels 1 and 3 and fault at level 2, whatever the host-mode and trap-general bits are.
- R8: In the non-secure state, primary-encoding accesses are always granted at level 3. At level 1 they are granted only when `trap_gen_i`=0 and fault otherwise. At level 2 they are granted only when `host_mode_i`=0.
- R9: A primary-encoding access at level 2 in the non-secure state with `host_mode_i`=1 raises `acc_redirect_o`, returns zero read data, and leaves the register unchanged.
- R10: The alias encoding op0=3, op1=5, CRn=15, CRm=7, op2=0 reaches the register only while `host_mode_i`=1. It is then granted at level 3, and at level 2 when non-secure, and it faults otherwise. While `host_mode_i`=0 it gets no response.
- R11: A faulted access leaves the register unchanged and returns zero read data.
- R12: A recognised access raises exactly one of `acc_ack_o`, `acc_fault_o` or `acc_redirect_o` for one cycle, one cycle after `acc_valid_i`. A granted read returns the stored value on `acc_rdata_o` in that same cycle, and `acc_rdata_o` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | System-register access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_op0_i | input | 2 | Access encoding op0 |
| acc_op1_i | input | 3 | Access encoding op1 |
| acc_crn_i | input | 4 | Access encoding CRn |
| acc_crm_i | input | 4 | Access encoding CRm |
| acc_op2_i | input | 3 | Access encoding op2 |
| acc_wdata_i | input | 64 | Write data |
| priv_lvl_i | input | 2 | Current privilege level 0..3 |
| secure_i | input | 1 | Secure state |
| host_mode_i | input | 1 | Hypervisor host mode |
| trap_gen_i | input | 1 | Trap-general-exceptions control |
| acc_ack_o | output | 1 | Access granted (one-cycle pulse) |
| acc_fault_o | output | 1 | Access not permitted (one-cycle pulse) |
| acc_redirect_o | output | 1 | Access redirected to the level-2 copy (one-cycle pulse) |
| acc_rdata_o | output | 64 | Read data, valid with a granted read |
| walk_valid_i | input | 1 | Walk request strobe |
| walk_upper_i | input | 1 | 0 = lower base, 1 = upper base |
| hint_valid_o | output | 1 | Hint valid, one cycle after the request |
| hint_o | output | 2 | Attribute hint for the walk |

## Verification
The hardest case to reach is a forbidden or redirected write that must leave no trace. Its only visible effect is the absence of change, which shows up only through a later permitted read. The bench therefore preloads a known pattern from level 3 before each access. It sweeps every combination of privilege level, security, host mode, trap-general, read/write and encoding (primary, alias, foreign). It then reads the register back from level 3 and compares the result with the pattern the permission rules predict. Hint gating is swept over all 256 field settings, on both bases.

// File: rtl/walk_hint_pkg.sv
package walk_hint_pkg;
  localparam int unsigned HINT_W     = 2;
  localparam int unsigned EN_LO_LSB  = 0;
  localparam int unsigned EN_HI_LSB  = 4;
  localparam int unsigned VAL_LO_LSB = 8;
  localparam int unsigned VAL_HI_LSB = 12;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_GRANT = 2'd1,
    RES_FAULT = 2'd2,
    RES_REDIR = 2'd3
  } acc_res_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;
endpackage

// File: rtl/whc_access_decode.sv
module whc_access_decode
  import walk_hint_pkg::*;
#(
  parameter sysreg_enc_t PRI_ENC   = {2'd3, 3'd0, 4'd15, 4'd7, 3'd0},
  parameter sysreg_enc_t ALIAS_ENC = {2'd3, 3'd5, 4'd15, 4'd7, 3'd0}
) (
  input  logic        valid_i,
  input  sysreg_enc_t enc_i,
  input  logic [1:0]  priv_i,
  input  logic        secure_i,
  input  logic        host_i,
  input  logic        tge_i,
  output acc_res_e    res_o
);
  logic pri_hit, alias_hit;
  assign pri_hit   = (enc_i == PRI_ENC);
  assign alias_hit = (enc_i == ALIAS_ENC) && host_i;

  always_comb begin
    res_o = RES_NONE;
    if (valid_i) begin
      if (pri_hit) begin
        case (priv_i)
          2'd0:    res_o = RES_FAULT;
          2'd1:    res_o = (secure_i || !tge_i) ? RES_GRANT : RES_FAULT;
          2'd2:    res_o = secure_i ? RES_FAULT : (host_i ? RES_REDIR : RES_GRANT);
          default: res_o = RES_GRANT;
        endcase
      end else if (alias_hit) begin
        res_o = (priv_i == 2'd3 || (priv_i == 2'd2 && !secure_i)) ? RES_GRANT : RES_FAULT;
      end
    end
  end
endmodule

// File: rtl/whc_field_store.sv
module whc_field_store #(
  parameter int unsigned REG_W = 64,
  parameter logic [REG_W-1:0] MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= '0;
    else if (we_i) ctl_o <= wdata_i & MASK;
  end

  // R11
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_o));
endmodule

// File: rtl/whc_hint_gen.sv
module whc_hint_gen #(
  parameter int unsigned HINT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              walk_valid_i,
  input  logic              walk_upper_i,
  input  logic [HINT_W-1:0] en_lo_i,
  input  logic [HINT_W-1:0] val_lo_i,
  input  logic [HINT_W-1:0] en_hi_i,
  input  logic [HINT_W-1:0] val_hi_i,
  output logic              hint_valid_o,
  output logic [HINT_W-1:0] hint_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hint_valid_o <= 1'b0;
    else         hint_valid_o <= walk_valid_i;
  end

  for (genvar k = 0; k < HINT_W; k++) begin : g_bit
    logic nxt;
    assign nxt = walk_valid_i &&
                 (walk_upper_i ? (en_hi_i[k] && val_hi_i[k]) : (en_lo_i[k] && val_lo_i[k]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hint_o[k] <= 1'b0;
      else         hint_o[k] <= nxt;
    end

    // R3
    enable_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hint_o[k] |-> $past(walk_upper_i ? en_hi_i[k] : en_lo_i[k]));
  end

  // R4
  hint_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_valid_i |=> hint_valid_o);
  // R4
  hint_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hint_valid_o |-> (hint_o == '0));
endmodule

// File: rtl/walk_hint_ctrl.sv
module walk_hint_ctrl
  import walk_hint_pkg::*;
#(
  parameter int unsigned REG_W = 64,
  parameter sysreg_enc_t PRI_ENC   = {2'd3, 3'd0, 4'd15, 4'd7, 3'd0},
  parameter sysreg_enc_t ALIAS_ENC = {2'd3, 3'd5, 4'd15, 4'd7, 3'd0}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [1:0]       acc_op0_i,
  input  logic [2:0]       acc_op1_i,
  input  logic [3:0]       acc_crn_i,
  input  logic [3:0]       acc_crm_i,
  input  logic [2:0]       acc_op2_i,
  input  logic [REG_W-1:0] acc_wdata_i,
  input  logic [1:0]       priv_lvl_i,
  input  logic             secure_i,
  input  logic             host_mode_i,
  input  logic             trap_gen_i,
  output logic             acc_ack_o,
  output logic             acc_fault_o,
  output logic             acc_redirect_o,
  output logic [REG_W-1:0] acc_rdata_o,
  input  logic             walk_valid_i,
  input  logic             walk_upper_i,
  output logic             hint_valid_o,
  output logic [HINT_W-1:0] hint_o
);
  localparam logic [REG_W-1:0] PAIR = REG_W'(3);
  localparam logic [REG_W-1:0] FIELD_MASK = (PAIR << EN_LO_LSB) | (PAIR << EN_HI_LSB) |
                                            (PAIR << VAL_LO_LSB) | (PAIR << VAL_HI_LSB);

  sysreg_enc_t      enc;
  acc_res_e         res_d, res_q;
  logic             we;
  logic [REG_W-1:0] ctl, rdata_q;

  assign enc = '{op0: acc_op0_i, op1: acc_op1_i, crn: acc_crn_i, crm: acc_crm_i, op2: acc_op2_i};

  whc_access_decode #(.PRI_ENC(PRI_ENC), .ALIAS_ENC(ALIAS_ENC)) u_dec (
    .valid_i (acc_valid_i),
    .enc_i   (enc),
    .priv_i  (priv_lvl_i),
    .secure_i(secure_i),
    .host_i  (host_mode_i),
    .tge_i   (trap_gen_i),
    .res_o   (res_d)
  );

  assign we = (res_d == RES_GRANT) && acc_write_i;

  whc_field_store #(.REG_W(REG_W), .MASK(FIELD_MASK)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .wdata_i(acc_wdata_i),
    .ctl_o  (ctl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= RES_NONE;
      rdata_q <= '0;
    end else begin
      res_q   <= res_d;
      rdata_q <= (res_d == RES_GRANT && !acc_write_i) ? ctl : '0;
    end
  end

  assign acc_ack_o      = (res_q == RES_GRANT);
  assign acc_fault_o    = (res_q == RES_FAULT);
  assign acc_redirect_o = (res_q == RES_REDIR);
  assign acc_rdata_o    = rdata_q;

  whc_hint_gen #(.HINT_W(HINT_W)) u_hint (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .walk_valid_i(walk_valid_i),
    .walk_upper_i(walk_upper_i),
    .en_lo_i     (ctl[EN_LO_LSB +: HINT_W]),
    .val_lo_i    (ctl[VAL_LO_LSB +: HINT_W]),
    .en_hi_i     (ctl[EN_HI_LSB +: HINT_W]),
    .val_hi_i    (ctl[VAL_HI_LSB +: HINT_W]),
    .hint_valid_o(hint_valid_o),
    .hint_o      (hint_o)
  );

  // R12
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_ack_o, acc_fault_o, acc_redirect_o}));
  // R2
  reserved_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rdata_o & ~FIELD_MASK) == '0);
  // R11
  fault_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_fault_o || acc_redirect_o) |-> (acc_rdata_o == '0));
  // R9
  redirect_keeps_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_redirect_o |-> $stable(ctl));
  // R6
  level0_faults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && enc == PRI_ENC && priv_lvl_i == 2'd0) |=> acc_fault_o);
endmodule

// File: tb/walk_hint_ctrl_tb.sv
module walk_hint_ctrl_tb;
  import walk_hint_pkg::*;

  localparam logic [63:0] M = 64'h3333;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        acc_valid = 0, acc_write = 0;
  sysreg_enc_t enc = '0;
  logic [63:0] wdata = '0;
  logic [1:0]  priv = 0;
  logic        sec = 0, host = 0, tge = 0;
  logic        ack, fault, redir, hv;
  logic [63:0] rdata;
  logic        walk_valid = 0, walk_upper = 0;
  logic [1:0]  hint;

  int checks = 0, fails = 0;
  bit done = 0;

  walk_hint_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_op0_i(enc.op0), .acc_op1_i(enc.op1), .acc_crn_i(enc.crn),
    .acc_crm_i(enc.crm), .acc_op2_i(enc.op2), .acc_wdata_i(wdata),
    .priv_lvl_i(priv), .secure_i(sec), .host_mode_i(host), .trap_gen_i(tge),
    .acc_ack_o(ack), .acc_fault_o(fault), .acc_redirect_o(redir), .acc_rdata_o(rdata),
    .walk_valid_i(walk_valid), .walk_upper_i(walk_upper),
    .hint_valid_o(hv), .hint_o(hint)
  );

  localparam sysreg_enc_t PRI   = {2'd3, 3'd0, 4'd15, 4'd7, 3'd0};
  localparam sysreg_enc_t ALIAS = {2'd3, 3'd5, 4'd15, 4'd7, 3'd0};
  localparam sysreg_enc_t OTHER = {2'd3, 3'd1, 4'd15, 4'd7, 3'd0};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {ack,fault,redir} and read data, sampled one cycle after the strobe
  task automatic access(input sysreg_enc_t e, input logic w, input logic [63:0] d,
                        input logic [1:0] p, input logic s, input logic h, input logic t,
                        output logic [2:0] outc, output logic [63:0] rd);
    @(negedge clk);
    enc = e; acc_write = w; wdata = d; priv = p; sec = s; host = h; tge = t; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    outc = {ack, fault, redir};
    rd = rdata;
  endtask

  task automatic load(input logic [63:0] d);
    logic [2:0] o; logic [63:0] r;
    access(PRI, 1'b1, d, 2'd3, 1'b1, 1'b0, 1'b0, o, r);
  endtask

  task automatic readback(output logic [63:0] r);
    logic [2:0] o;
    access(PRI, 1'b0, 64'h0, 2'd3, 1'b1, 1'b0, 1'b0, o, r);
  endtask

  task automatic walk(input logic u, output logic v, output logic [1:0] hh);
    @(negedge clk);
    walk_valid = 1; walk_upper = u;
    @(negedge clk);
    walk_valid = 0;
    v = hv; hh = hint;
  endtask

  // expected outcome code: 4 grant, 2 fault, 1 redirect, 0 none
  function automatic logic [2:0] model(input int e, input logic [1:0] p,
                                       input logic s, input logic h, input logic t);
    if (e == 0) begin
      if (p == 0) return 3'b010;
      if (p == 3) return 3'b100;
      if (s) return (p == 1) ? 3'b100 : 3'b010;
      if (p == 1) return t ? 3'b010 : 3'b100;
      return h ? 3'b001 : 3'b100;
    end
    if (e == 1) begin
      if (!h) return 3'b000;
      if (p == 3 || (p == 2 && !s)) return 3'b100;
      return 3'b010;
    end
    return 3'b000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] o; logic [63:0] r; logic v; logic [1:0] hh;
    repeat (3) @(negedge clk);
    // R1 outputs idle during reset
    chk("R1 reset outcome", {61'd0, ack, fault, redir}, 64'd0);
    chk("R1 reset hint valid", {63'd0, hv}, 64'd0);
    rst_n = 1;
    readback(r);
    chk("R1 reset read", r, 64'd0);
    walk(1'b0, v, hh); chk("R1 reset hint lower", {62'd0, hh}, 64'd0);
    walk(1'b1, v, hh); chk("R1 reset hint upper", {62'd0, hh}, 64'd0);
    @(negedge clk);
    chk("R4 hint idle valid", {63'd0, hv}, 64'd0);
    chk("R12 outcome idle", {61'd0, ack, fault, redir}, 64'd0);

    // R2 reserved bits discarded
    load(64'hFFFF_FFFF_FFFF_FFFF);
    readback(r);
    chk("R2 all-ones write masked", r, M);

    // access permission sweep
    for (int e = 0; e < 3; e++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++)
          for (int h = 0; h < 2; h++)
            for (int t = 0; t < 2; t++)
              for (int w = 0; w < 2; w++) begin
                logic [63:0] pre, nw, exp_rd, exp_reg;
                logic [2:0] exp_o;
                sysreg_enc_t ee;
                pre = 64'hFFFF_0000_FFFF_1221 ^ {60'd0, 4'(p*4 + s*2 + h)};
                nw  = 64'hAAAA_5555_AAAA_ACCE ^ {56'd0, 8'(e*16 + t*8 + w)};
                ee  = (e == 0) ? PRI : (e == 1) ? ALIAS : OTHER;
                load(pre);
                access(ee, w[0], nw, p[1:0], s[0], h[0], t[0], o, r);
                exp_o   = model(e, p[1:0], s[0], h[0], t[0]);
                exp_rd  = (exp_o == 3'b100 && w == 0) ? (pre & M) : 64'd0;
                exp_reg = (exp_o == 3'b100 && w == 1) ? (nw & M) : (pre & M);
                // R5 R6 R7 R8 R9 R10 R12 outcome per matrix
                chk($sformatf("R5-matrix outcome e%0d p%0d s%0d h%0d t%0d w%0d R6 R7 R8 R9 R10 R12", e, p, s, h, t, w),
                    {61'd0, o}, {61'd0, exp_o});
                // R11 R12 read data
                chk($sformatf("R11 R12 rdata e%0d p%0d s%0d h%0d t%0d w%0d", e, p, s, h, t, w), r, exp_rd);
                readback(r);
                // R2 R9 R11 register content afterwards
                chk($sformatf("R2 R9 R11 stored e%0d p%0d s%0d h%0d t%0d w%0d", e, p, s, h, t, w), r, exp_reg);
              end

    // R3 R4 hint sweep over every field setting
    for (int x = 0; x < 256; x++) begin
      logic [7:0] b;
      logic [63:0] d;
      b = 8'(x);
      d = 64'hDEAD_BEEF_0000_CCCC & ~M;
      d[1:0] = b[1:0]; d[5:4] = b[3:2]; d[9:8] = b[5:4]; d[13:12] = b[7:6];
      load(d);
      walk(1'b0, v, hh);
      chk($sformatf("R4 valid lower %0d", x), {63'd0, v}, 64'd1);
      chk($sformatf("R3 hint lower %0d", x), {62'd0, hh}, {62'd0, b[1:0] & b[5:4]});
      walk(1'b1, v, hh);
      chk($sformatf("R4 valid upper %0d", x), {63'd0, v}, 64'd1);
      chk($sformatf("R3 hint upper %0d", x), {62'd0, hh}, {62'd0, b[3:2] & b[7:6]});
    end
    @(negedge clk);
    chk("R4 hint zero when idle", {61'd0, hv, hint}, 64'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule